// File: doc/BRIEF.md
# Qubit Experiment Sweep Sequencer

This block steps the parameters of a repeated qubit characterization experiment and tells a pulse playback controller what to play. The host gives it an experiment kind, a repetition count, a point count, and a base value plus a per-point increment for three quantities: pulse amplitude, readout trigger delay and a time span. On `start`, it captures all of these. For each parameter point, it issues one command the programmed number of times and waits for the playback `play_done` flag after each issue. When a point's repetitions are finished, it moves the swept quantity on by its increment.

The experiment kind picks which quantity sweeps and how the command is shaped:
- A power sweep changes the amplitude of a single pulse.
- A duration sweep changes the length of a flat section placed in the middle of a single shaped pulse.
- A decay measurement plays one fixed pulse and changes the wait before the readout trigger.
- A two-pulse interference measurement changes the gap between a pulse pair, and the readout is triggered right at the end of the second pulse.

Swept values stop at the largest value their width can hold and never wrap. `busy` and the current point index can be read at the ports. `abort` returns the block to idle on the next clock.

Top module: `qubit_sweep_seq`

## Requirements
- R1: After synchronous reset, `busy`, `play_go` and `step_idx` are all 0.
- R2: A `start` pulse while idle, with `rep_count` and `step_count` both non-zero, makes `busy` 1 and `play_go` 1 in the cycle after the clock edge that samples `start`. If either count is zero, `start` has no effect.
- R3: For every point, `play_go` is high for exactly one cycle per repetition, `rep_count` times. After each issue, no further `play_go` comes until `play_done` has been seen high.
- R4: `exp_kind` = 0 (power sweep): `pulse_pair` = 0, `pulse_amp` = amp_base + k*amp_step for point k, `trig_dly` = dly_base, `flat_len` = 0, `pulse_gap` = 0.
- R5: `exp_kind` = 1 (duration sweep): `pulse_pair` = 0, `pulse_amp` = amp_base, `flat_len` = span_base + k*span_step, `trig_dly` = dly_base, `pulse_gap` = 0.
- R6: `exp_kind` = 2 (decay): `pulse_pair` = 0, `pulse_amp` = amp_base, `trig_dly` = dly_base + k*dly_step, `flat_len` = 0, `pulse_gap` = 0.
- R7: `exp_kind` = 3 (two-pulse interference): `pulse_pair` = 1, `pulse_amp` = amp_base, `pulse_gap` = span_base + k*span_step, `trig_dly` = 0, `flat_len` = 0.
- R8: A swept value that would exceed 2^width-1 is held at 2^width-1. It never wraps.
- R9: While busy, `step_idx` equals the index k of the point being played. After the last `play_done` of the last point, `busy` and `step_idx` are 0 on the next cycle.
- R10: `abort` makes `busy` and `play_go` 0 on the next cycle. No further command is issued until a new `start`.
- R11: Changes to the configuration inputs after `start` have no effect on the run. A `play_done` that arrives while idle or during an issue cycle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run, captures configuration |
| abort | input | 1 | Return to idle on next clock |
| exp_kind | input | 2 | 0 power, 1 duration, 2 decay, 3 two-pulse |
| rep_count | input | REP_W | Repetitions per point |
| step_count | input | STEP_W | Number of points |
| amp_base | input | AMP_W | Amplitude at point 0 |
| amp_step | input | AMP_W | Amplitude increment per point |
| dly_base | input | TIME_W | Trigger delay at point 0 |
| dly_step | input | TIME_W | Trigger delay increment per point |
| span_base | input | TIME_W | Flat length or gap at point 0 |
| span_step | input | TIME_W | Flat length or gap increment per point |
| play_done | input | 1 | Playback finished the last command |
| busy | output | 1 | Run in progress |
| step_idx | output | STEP_W | Current point index |
| play_go | output | 1 | One-cycle command strobe |
| pulse_pair | output | 1 | Command plays two pulses |
| pulse_amp | output | AMP_W | Pulse amplitude |
| flat_len | output | TIME_W | Flat section inserted mid-pulse |
| pulse_gap | output | TIME_W | Gap between the two pulses |
| trig_dly | output | TIME_W | Delay from end of last pulse to readout trigger |

## Verification
A wrong repetition or point counter shows up at the first point boundary. The command fields would change one issue too early or too late, or `step_idx` would skip. The bench compares every issued command against arithmetic expectations, so it sees this on the first mismatching `play_go`. A swept value that wraps shows as a sudden drop in a field on the next point. A state machine that does not wait for `play_done` shows as a `play_go` during the hold cycles, which the bench watches cycle by cycle. A lost `abort` or a missed end of run leaves `busy` high on the cycle after the event.

// File: rtl/sweep_pkg.sv
package sweep_pkg;

    typedef enum logic [1:0] {
        EXP_PWR   = 2'd0,
        EXP_DUR   = 2'd1,
        EXP_DECAY = 2'd2,
        EXP_PAIR  = 2'd3
    } exp_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic load;
        logic rep_next;
        logic step_next;
        logic finish;
    } seq_ctl_t;

    // index 0 amplitude, 1 trigger delay, 2 span
    localparam int NUM_SWEEP = 3;

    function automatic logic [NUM_SWEEP-1:0] sweep_mask(exp_kind_e k);
        logic [NUM_SWEEP-1:0] m;
        m = '0;
        case (k)
            EXP_PWR:   m[0] = 1'b1;
            EXP_DECAY: m[1] = 1'b1;
            EXP_DUR,
            EXP_PAIR:  m[2] = 1'b1;
            default:   m = '0;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/sweep_acc.sv
module sweep_acc #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic         adv,
    input  logic [W-1:0] base,
    input  logic [W-1:0] step,
    output logic [W-1:0] val
);
    logic [W-1:0] step_q;
    logic [W:0]   sum;

    assign sum = {1'b0, val} + {1'b0, step_q};

    always_ff @(posedge clk) begin
        if (rst) begin
            val    <= '0;
            step_q <= '0;
        end else if (load) begin
            val    <= base;
            step_q <= step;
        end else if (adv) begin
            val <= sum[W] ? {W{1'b1}} : sum[W-1:0];
        end
    end
endmodule

// File: rtl/sweep_count.sv
module sweep_count #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic         clr,
    input  logic         inc,
    input  logic [W-1:0] limit,
    output logic [W-1:0] val,
    output logic         last
);
    localparam logic [W-1:0] ONE = W'(1);
    logic [W-1:0] lim_q;

    assign last = (val == lim_q - ONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            val   <= '0;
            lim_q <= '0;
        end else if (load) begin
            val   <= '0;
            lim_q <= limit;
        end else if (clr) begin
            val <= '0;
        end else if (inc) begin
            val <= val + ONE;
        end
    end
endmodule

// File: rtl/sweep_fsm.sv
module sweep_fsm
    import sweep_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic       abort,
    input  logic       counts_ok,
    input  logic       play_done,
    input  logic       rep_last,
    input  logic       step_last,
    output seq_state_e state,
    output seq_ctl_t   ctl
);
    seq_state_e nxt;

    always_comb begin
        nxt = state;
        ctl = '0;
        case (state)
            ST_IDLE: begin
                if (start && counts_ok) begin
                    nxt      = ST_ISSUE;
                    ctl.load = 1'b1;
                end
            end
            ST_ISSUE: nxt = ST_WAIT;
            ST_WAIT: begin
                if (play_done) begin
                    if (!rep_last) begin
                        nxt          = ST_ISSUE;
                        ctl.rep_next = 1'b1;
                    end else if (!step_last) begin
                        nxt           = ST_ISSUE;
                        ctl.step_next = 1'b1;
                    end else begin
                        nxt        = ST_IDLE;
                        ctl.finish = 1'b1;
                    end
                end
            end
            default: nxt = ST_IDLE;
        endcase
        if (abort) begin
            nxt        = ST_IDLE;
            ctl        = '0;
            ctl.finish = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nxt;
    end
endmodule

// File: rtl/sweep_map.sv
module sweep_map
    import sweep_pkg::*;
#(
    parameter int AMP_W  = 12,
    parameter int TIME_W = 16
) (
    input  exp_kind_e         kind,
    input  logic [AMP_W-1:0]  amp_v,
    input  logic [TIME_W-1:0] dly_v,
    input  logic [TIME_W-1:0] span_v,
    output logic              pair,
    output logic [AMP_W-1:0]  amp,
    output logic [TIME_W-1:0] flat,
    output logic [TIME_W-1:0] gap,
    output logic [TIME_W-1:0] trig
);
    always_comb begin
        pair = 1'b0;
        amp  = amp_v;
        flat = '0;
        gap  = '0;
        trig = dly_v;
        case (kind)
            EXP_DUR:  flat = span_v;
            EXP_PAIR: begin
                pair = 1'b1;
                gap  = span_v;
                trig = '0;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/qubit_sweep_seq.sv
module qubit_sweep_seq
    import sweep_pkg::*;
#(
    parameter int AMP_W  = 12,
    parameter int TIME_W = 16,
    parameter int REP_W  = 8,
    parameter int STEP_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              abort,
    input  logic [1:0]        exp_kind,
    input  logic [REP_W-1:0]  rep_count,
    input  logic [STEP_W-1:0] step_count,
    input  logic [AMP_W-1:0]  amp_base,
    input  logic [AMP_W-1:0]  amp_step,
    input  logic [TIME_W-1:0] dly_base,
    input  logic [TIME_W-1:0] dly_step,
    input  logic [TIME_W-1:0] span_base,
    input  logic [TIME_W-1:0] span_step,
    input  logic              play_done,
    output logic              busy,
    output logic [STEP_W-1:0] step_idx,
    output logic              play_go,
    output logic              pulse_pair,
    output logic [AMP_W-1:0]  pulse_amp,
    output logic [TIME_W-1:0] flat_len,
    output logic [TIME_W-1:0] pulse_gap,
    output logic [TIME_W-1:0] trig_dly
);
    localparam int NUM_TIME = 2;

    seq_state_e state;
    seq_ctl_t   ctl;
    exp_kind_e  kind_q;
    logic       rep_last, step_last, counts_ok;
    logic [REP_W-1:0]     rep_val;
    logic [NUM_SWEEP-1:0] adv_mask;
    logic [AMP_W-1:0]     amp_v;
    logic [TIME_W-1:0]    t_base [NUM_TIME];
    logic [TIME_W-1:0]    t_step [NUM_TIME];
    logic [TIME_W-1:0]    t_val  [NUM_TIME];

    assign counts_ok = (rep_count != '0) && (step_count != '0);
    assign busy      = (state != ST_IDLE);
    assign play_go   = (state == ST_ISSUE);
    assign adv_mask  = sweep_mask(kind_q) & {NUM_SWEEP{ctl.step_next}};

    always_ff @(posedge clk) begin
        if (rst)           kind_q <= EXP_PWR;
        else if (ctl.load) kind_q <= exp_kind_e'(exp_kind);
    end

    sweep_fsm u_fsm (
        .clk(clk), .rst(rst), .start(start), .abort(abort),
        .counts_ok(counts_ok), .play_done(play_done),
        .rep_last(rep_last), .step_last(step_last),
        .state(state), .ctl(ctl)
    );

    sweep_count #(.W(REP_W)) u_rep (
        .clk(clk), .rst(rst), .load(ctl.load),
        .clr(ctl.step_next | ctl.finish), .inc(ctl.rep_next),
        .limit(rep_count), .val(rep_val), .last(rep_last)
    );

    sweep_count #(.W(STEP_W)) u_step (
        .clk(clk), .rst(rst), .load(ctl.load),
        .clr(ctl.finish), .inc(ctl.step_next),
        .limit(step_count), .val(step_idx), .last(step_last)
    );

    sweep_acc #(.W(AMP_W)) u_amp (
        .clk(clk), .rst(rst), .load(ctl.load), .adv(adv_mask[0]),
        .base(amp_base), .step(amp_step), .val(amp_v)
    );

    assign t_base[0] = dly_base;
    assign t_step[0] = dly_step;
    assign t_base[1] = span_base;
    assign t_step[1] = span_step;

    for (genvar gi = 0; gi < NUM_TIME; gi++) begin : g_time
        sweep_acc #(.W(TIME_W)) u_t (
            .clk(clk), .rst(rst), .load(ctl.load), .adv(adv_mask[gi+1]),
            .base(t_base[gi]), .step(t_step[gi]), .val(t_val[gi])
        );
    end

    sweep_map #(.AMP_W(AMP_W), .TIME_W(TIME_W)) u_map (
        .kind(kind_q), .amp_v(amp_v), .dly_v(t_val[0]), .span_v(t_val[1]),
        .pair(pulse_pair), .amp(pulse_amp), .flat(flat_len),
        .gap(pulse_gap), .trig(trig_dly)
    );

    logic unused_ok;
    assign unused_ok = ^rep_val;
endmodule

// File: rtl/qubit_sweep_seq_chk.sv
module qubit_sweep_seq_chk #(
    parameter int AMP_W  = 12,
    parameter int TIME_W = 16,
    parameter int STEP_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              abort,
    input logic              busy,
    input logic              play_go,
    input logic [STEP_W-1:0] step_idx,
    input logic              pulse_pair,
    input logic [AMP_W-1:0]  pulse_amp,
    input logic [TIME_W-1:0] flat_len,
    input logic [TIME_W-1:0] pulse_gap,
    input logic [TIME_W-1:0] trig_dly
);
    localparam logic [STEP_W-1:0] S_ONE = STEP_W'(1);

    // R10
    abort_idle_chk: assert property (@(posedge clk) disable iff (rst)
        abort |=> (!busy && !play_go));

    // R3
    single_go_chk: assert property (@(posedge clk) disable iff (rst)
        play_go |=> !play_go);

    // R2
    first_go_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> play_go);

    // R9
    idle_index_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (step_idx == '0));

    // R9
    index_step_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |->
            ((step_idx == $past(step_idx)) || (step_idx == $past(step_idx) + S_ONE)));

    // R8
    no_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |->
            (pulse_amp >= $past(pulse_amp) && flat_len >= $past(flat_len) &&
             pulse_gap >= $past(pulse_gap) && trig_dly >= $past(trig_dly)));

    // R7
    pair_trig_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && pulse_pair) |-> (trig_dly == '0 && flat_len == '0));
endmodule

bind qubit_sweep_seq qubit_sweep_seq_chk #(
    .AMP_W(AMP_W), .TIME_W(TIME_W), .STEP_W(STEP_W)
) u_chk (
    .clk(clk), .rst(rst), .abort(abort), .busy(busy), .play_go(play_go),
    .step_idx(step_idx), .pulse_pair(pulse_pair), .pulse_amp(pulse_amp),
    .flat_len(flat_len), .pulse_gap(pulse_gap), .trig_dly(trig_dly)
);

// File: tb/qubit_sweep_seq_test.sv
`timescale 1ns/1ps
module qubit_sweep_seq_test;
    localparam int AMP_W  = 12;
    localparam int TIME_W = 16;
    localparam int REP_W  = 8;
    localparam int STEP_W = 8;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic              rst, start, abort, play_done;
    logic [1:0]        exp_kind;
    logic [REP_W-1:0]  rep_count;
    logic [STEP_W-1:0] step_count;
    logic [AMP_W-1:0]  amp_base, amp_step;
    logic [TIME_W-1:0] dly_base, dly_step, span_base, span_step;
    logic              busy, play_go, pulse_pair;
    logic [STEP_W-1:0] step_idx;
    logic [AMP_W-1:0]  pulse_amp;
    logic [TIME_W-1:0] flat_len, pulse_gap, trig_dly;

    int errs = 0;
    int checks = 0;

    qubit_sweep_seq #(.AMP_W(AMP_W), .TIME_W(TIME_W), .REP_W(REP_W), .STEP_W(STEP_W)) uut (
        .clk(clk), .rst(rst), .start(start), .abort(abort), .exp_kind(exp_kind),
        .rep_count(rep_count), .step_count(step_count),
        .amp_base(amp_base), .amp_step(amp_step), .dly_base(dly_base), .dly_step(dly_step),
        .span_base(span_base), .span_step(span_step), .play_done(play_done),
        .busy(busy), .step_idx(step_idx), .play_go(play_go), .pulse_pair(pulse_pair),
        .pulse_amp(pulse_amp), .flat_len(flat_len), .pulse_gap(pulse_gap), .trig_dly(trig_dly)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic longint satv(longint b, longint s, int k, int w);
        longint v, m;
        v = b + s * k;
        m = (longint'(1) << w) - 1;
        return (v > m) ? m : v;
    endfunction

    task automatic wait_go();
        int n = 0;
        while (!play_go && n < 40) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic pulse_done();
        play_done = 1'b1;
        @(negedge clk);
        play_done = 1'b0;
    endtask

    task automatic run_case(input int kind, input int reps, input int steps,
                            input longint ab, input longint as_, input longint db,
                            input longint ds, input longint sb, input longint ss);
        string tag;
        longint e_amp, e_flat, e_gap, e_trig;
        tag = (kind == 0) ? "R4" : (kind == 1) ? "R5" : (kind == 2) ? "R6" : "R7";
        @(negedge clk);
        exp_kind = 2'(kind); rep_count = REP_W'(reps); step_count = STEP_W'(steps);
        amp_base = AMP_W'(ab); amp_step = AMP_W'(as_);
        dly_base = TIME_W'(db); dly_step = TIME_W'(ds);
        span_base = TIME_W'(sb); span_step = TIME_W'(ss);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        // R11: scramble configuration after capture
        exp_kind = 2'(~kind); rep_count = 8'd200; step_count = 8'd200;
        amp_base = '0; amp_step = 12'd999; dly_base = '0; dly_step = 16'd5;
        span_base = '0; span_step = 16'd7;
        for (int k = 0; k < steps; k++) begin
            e_amp  = (kind == 0) ? satv(ab, as_, k, AMP_W) : ab;
            e_flat = (kind == 1) ? satv(sb, ss, k, TIME_W) : 0;
            e_gap  = (kind == 3) ? satv(sb, ss, k, TIME_W) : 0;
            e_trig = (kind == 2) ? satv(db, ds, k, TIME_W) : (kind == 3) ? 0 : db;
            for (int r = 0; r < reps; r++) begin
                wait_go();
                chk(play_go == 1'b1, "R3 go", play_go, 1);
                chk(step_idx == STEP_W'(k), "R9 index", step_idx, k);
                chk(pulse_amp == AMP_W'(e_amp), tag, pulse_amp, e_amp);
                chk(flat_len == TIME_W'(e_flat), tag, flat_len, e_flat);
                chk(pulse_gap == TIME_W'(e_gap), tag, pulse_gap, e_gap);
                chk(trig_dly == TIME_W'(e_trig), tag, trig_dly, e_trig);
                chk(pulse_pair == (kind == 3), tag, pulse_pair, kind == 3);
                if (e_amp == 4095 || (kind != 3 && e_trig == 65535) || e_flat == 65535 || e_gap == 65535)
                    chk(1'b1 && (pulse_amp == AMP_W'(e_amp)), "R8 saturate", pulse_amp, e_amp);
                if (k == 0 && r == 0) begin
                    // R11: done during the issue cycle is ignored
                    play_done = 1'b1;
                    @(negedge clk);
                    play_done = 1'b0;
                end else begin
                    @(negedge clk);
                end
                repeat (2) begin
                    chk(!play_go && busy, "R3 hold", play_go, 0);
                    @(negedge clk);
                end
                pulse_done();
            end
        end
        chk(busy == 1'b0, "R9 end busy", busy, 0);
        chk(step_idx == '0, "R9 end index", step_idx, 0);
        repeat (3) begin
            @(negedge clk);
            chk(play_go == 1'b0, "R3 no extra go", play_go, 0);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    endtask

    initial begin
        #(5.0 * 150000);
        errs++;
        checks++;
        $display("FAIL watchdog expired actual=1 expected=0");
        finish_run();
    end

    initial begin
        rst = 1'b1; start = 1'b0; abort = 1'b0; play_done = 1'b0;
        exp_kind = '0; rep_count = '0; step_count = '0;
        amp_base = '0; amp_step = '0; dly_base = '0; dly_step = '0;
        span_base = '0; span_step = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(busy == 1'b0, "R1 busy", busy, 0);
        chk(play_go == 1'b0, "R1 go", play_go, 0);
        chk(step_idx == '0, "R1 index", step_idx, 0);

        // R11: done while idle
        pulse_done();
        chk(busy == 1'b0, "R11 idle done", busy, 0);

        // R2: zero counts ignored
        rep_count = 8'd0; step_count = 8'd3; start = 1'b1;
        @(negedge clk); start = 1'b0;
        repeat (2) @(negedge clk);
        chk(busy == 1'b0 && play_go == 1'b0, "R2 zero reps", busy, 0);
        rep_count = 8'd2; step_count = 8'd0; start = 1'b1;
        @(negedge clk); start = 1'b0;
        repeat (2) @(negedge clk);
        chk(busy == 1'b0 && play_go == 1'b0, "R2 zero steps", busy, 0);

        for (int kind = 0; kind < 4; kind++) begin
            run_case(kind, 2, 4, 4000, 37, 65000, 300, 65400, 60);
            run_case(kind, 1, 3, 10, 5, 20, 7, 30, 9);
            run_case(kind, 3, 2, 4095, 4095, 65535, 65535, 65535, 65535);
        end

        // R10: abort mid-run
        @(negedge clk);
        exp_kind = 2'd3; rep_count = 8'd2; step_count = 8'd3;
        amp_base = 12'd100; span_base = 16'd50; span_step = 16'd10;
        start = 1'b1;
        @(negedge clk); start = 1'b0;
        wait_go();
        @(negedge clk);
        pulse_done();
        wait_go();
        chk(play_go == 1'b1, "R10 second go", play_go, 1);
        abort = 1'b1;
        @(negedge clk);
        abort = 1'b0;
        chk(busy == 1'b0, "R10 busy", busy, 0);
        chk(play_go == 1'b0, "R10 go", play_go, 0);
        chk(step_idx == '0, "R10 index", step_idx, 0);
        pulse_done();
        repeat (3) begin
            chk(play_go == 1'b0 && busy == 1'b0, "R10 stays idle", play_go, 0);
            @(negedge clk);
        end
        run_case(1, 2, 2, 300, 1, 40, 2, 8, 4);

        finish_run();
    end
endmodule